// File: doc/BRIEF.md
# Dithered DAC Sample Controller

This block turns a 16-bit audio-style sample into an 8-bit code for a simple DAC, updated on every system clock. The upper byte of the sample is the base level; the lower byte is a fraction that is realised over time by nudging the code up one step on a share of clocks equal to that fraction out of 256. Two ways of choosing those clocks are offered: a pseudo-random comparison source or a free-running ramp, which gives a PWM pattern.

Samples arrive on a valid/ready write port. A programmable period, counted in system clocks, sets the sample rate. A newly written sample waits in a holding register until the next period boundary and then drives the output. A period-complete flag rises at each boundary and tells software when to supply the next sample. Driving the enable input low parks the whole block with the output at zero.

The write port's back-pressure rule is simple. Ready follows the enable input. While the block is enabled, every valid beat is taken. A second write before a boundary replaces the held sample, and nothing is queued.

Top module: `dither_dac_ctrl`

## Requirements
- R1: While `en` is low, on the next clock edge the counters return to their start state and the held and active samples are cleared to 0. After that edge `dac_code` is 0 and `period_done` is 0.
- R2: Out of reset, `smp_ready` equals `en`. A beat is accepted on a clock edge where `smp_valid` and `smp_ready` are both high. A later accepted beat replaces an earlier one that has not yet taken effect.
- R3: A period boundary occurs every P enabled clocks, where P is `cfg_period`; a value of 0 behaves as 1. `period_done` goes high on the clock after each boundary and stays high until a write is accepted.
- R4: An accepted write clears `period_done` on the next clock, even if a boundary falls in the same cycle.
- R5: An accepted sample becomes active at the first boundary after it is accepted; `dac_code` reflects it one clock after that boundary. A write in the same cycle as a boundary waits for the following boundary.
- R6: When `cfg_mode`=0 (random), each clock `dac_code` is base+1 if the low 8 bits of a 16-bit Galois LFSR are below the fraction, and base otherwise. Base is active[15:8] and the fraction is active[7:0]. The LFSR shifts right and XORs 0xB400 when the bit shifted out is 1. It is loaded with 0xACE1 while disabled and advances on every enabled clock.
- R7: When `cfg_mode`=1 (PWM), an 8-bit counter that is 0 on the first enabled clock and increments every enabled clock replaces the LFSR value in the R6 comparison.
- R8: When the base is 255, `dac_code` stays at 255 whatever the fraction.
- R9: A fraction of 0 gives a constant code equal to the base; an active sample of 0x8000 gives a steady code of 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low parks counters and zeroes output |
| cfg_mode | input | 1 | Dither style: 0 random, 1 PWM |
| cfg_period | input | 16 | Sample period in system clocks (0 acts as 1) |
| smp_valid | input | 1 | Sample write valid |
| smp_data | input | 16 | Sample: base level in [15:8], fraction in [7:0] |
| smp_ready | output | 1 | Sample write ready (follows enable) |
| dac_code | output | 8 | Code to the DAC, updated every clock |
| period_done | output | 1 | Period-complete flag polled before each write |

## Verification
The bench builds the block with its default widths of 16-bit samples, 8-bit codes and a 16-bit period. Because it drives periods between 0 and 40 clocks instead of audio-scale values, a run of a few thousand cycles reaches hundreds of period boundaries. That includes writes that coincide with a boundary, back-to-back writes that replace a held sample, and enable drops in the middle of a period. Samples with a top base, a zero fraction or a full fraction are mixed into the random stream, so saturation and the two ends of the dither comparison come up in both modes.

// File: rtl/dac_dith_pkg.sv
package dac_dith_pkg;
  typedef enum logic {
    DITH_RAND = 1'b0,
    DITH_PWM  = 1'b1
  } dith_mode_e;
endpackage

// File: rtl/dac_period_timer.sv
module dac_period_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] last_idx;

  // Zero period is treated as one clock per sample.
  assign last_idx = (period == '0) ? '0 : period - PER_W'(1);
  // Comparison uses >= so a shortened period takes effect at once.
  assign tick     = en && (cnt_q >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + PER_W'(1);
  end
endmodule

// File: rtl/dac_sample_latch.sv
module dac_sample_latch #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic [DATA_W-1:0] act_q,
  output logic              done_q
);
  logic [DATA_W-1:0] hold_q;
  logic              hold_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
      act_q    <= '0;
      done_q   <= 1'b0;
    end else if (!en) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
      act_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      if (tick && hold_v_q) act_q <= hold_q;
      if (wr) begin
        hold_q   <= wr_data;
        hold_v_q <= 1'b1;
      end else if (tick) begin
        hold_v_q <= 1'b0;
      end
      // A write outranks a boundary in the same cycle.
      if (wr)        done_q <= 1'b0;
      else if (tick) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dac_dither_src.sv
module dac_dither_src
  import dac_dith_pkg::*;
#(
  parameter int              CMP_W  = 8,
  parameter int              LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  dith_mode_e       mode,
  output logic [CMP_W-1:0] cmp_val
);
  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_nxt;
  logic [CMP_W-1:0]  ramp_q;
  logic [CMP_W-1:0]  rnd_val;

  assign lfsr_nxt = lfsr_q[0] ? ((lfsr_q >> 1) ^ TAPS) : (lfsr_q >> 1);

  generate
    if (LFSR_W >= CMP_W) begin : g_rnd_slice
      assign rnd_val = lfsr_q[CMP_W-1:0];
    end else begin : g_rnd_pad
      assign rnd_val = {{(CMP_W-LFSR_W){1'b0}}, lfsr_q};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      ramp_q <= '0;
    end else if (!en) begin
      lfsr_q <= SEED;
      ramp_q <= '0;
    end else begin
      lfsr_q <= lfsr_nxt;
      ramp_q <= ramp_q + CMP_W'(1);
    end
  end

  assign cmp_val = (mode == DITH_PWM) ? ramp_q : rnd_val;
endmodule

// File: rtl/dac_code_gen.sv
module dac_code_gen #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 8,
  localparam int FRAC_W = DATA_W - CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] smp,
  input  logic [FRAC_W-1:0] cmp,
  output logic [CODE_W-1:0] code_q
);
  logic [CODE_W-1:0] base;
  logic [FRAC_W-1:0] frac;
  logic              bump;

  assign base = smp[DATA_W-1:FRAC_W];
  assign frac = smp[FRAC_W-1:0];
  assign bump = (cmp < frac) && !(&base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= '0;
    else if (!en)  code_q <= '0;
    else           code_q <= bump ? base + CODE_W'(1) : base;
  end
endmodule

// File: rtl/dither_dac_ctrl.sv
module dither_dac_ctrl
  import dac_dith_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter int              CODE_W    = 8,
  parameter int              PER_W     = 16,
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_mode,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              smp_ready,
  output logic [CODE_W-1:0] dac_code,
  output logic              period_done
);
  localparam int FRAC_W = DATA_W - CODE_W;

  logic              tick;
  logic              wr_acc;
  logic [DATA_W-1:0] act_q;
  logic [FRAC_W-1:0] cmp_val;
  dith_mode_e        mode;

  assign smp_ready = en && rst_n;
  assign wr_acc    = smp_valid && smp_ready;
  assign mode      = dith_mode_e'(cfg_mode);

  dac_period_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .period(cfg_period), .tick(tick)
  );

  dac_sample_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .en(en), .wr(wr_acc), .wr_data(smp_data),
    .tick(tick), .act_q(act_q), .done_q(period_done)
  );

  dac_dither_src #(
    .CMP_W(FRAC_W), .LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
  ) u_src (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cmp_val(cmp_val)
  );

  dac_code_gen #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .en(en), .smp(act_q), .cmp(cmp_val),
    .code_q(dac_code)
  );
endmodule

// File: rtl/dac_dith_checker.sv
module dac_dith_checker #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 8,
  localparam int FRAC_W = DATA_W - CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic              period_done,
  input logic [CODE_W-1:0] dac_code,
  input logic [DATA_W-1:0] act_smp
);
  // R1: disabled block parks with zero output and no flag
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (dac_code == '0) && !period_done);

  // R4: accepted write clears the flag
  p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && smp_valid && smp_ready) |=> !period_done);

  // R6, R7: code is the base or one step above it
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> (dac_code == $past(act_smp[DATA_W-1:FRAC_W]) ||
                   dac_code == $past(act_smp[DATA_W-1:FRAC_W]) + CODE_W'(1)));

  // R8: top base saturates
  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && (&$past(act_smp[DATA_W-1:FRAC_W]))) |-> (&dac_code));

  // R9: zero fraction gives the bare base
  p_frac_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && ($past(act_smp[FRAC_W-1:0]) == '0)) |->
      (dac_code == $past(act_smp[DATA_W-1:FRAC_W])));
endmodule

bind dither_dac_ctrl dac_dith_checker #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .period_done(period_done), .dac_code(dac_code),
  .act_smp(act_q)
);

// File: tb/dither_dac_ctrl_tb.sv
`timescale 1ns/1ps
module dither_dac_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [15:0] cfg_period = 16'd16;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        smp_ready;
  logic [7:0]  dac_code;
  logic        period_done;

  int nvec = 0;
  int nfail = 0;
  string ctag = "R6";

  always #2.5 clk = ~clk;

  dither_dac_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_mode(cfg_mode),
    .cfg_period(cfg_period), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .dac_code(dac_code), .period_done(period_done)
  );

  // Reference model built from the requirements
  logic [15:0] m_cnt, m_lfsr, m_act, m_hold;
  logic [7:0]  m_ramp, m_code;
  logic        m_hv, m_flag;

  function automatic logic [15:0] lfsr_step(logic [15:0] v);
    return v[0] ? ((v >> 1) ^ 16'hB400) : (v >> 1);
  endfunction

  function automatic logic [7:0] exp_code(logic [15:0] s, logic [7:0] c);
    if (s[15:8] == 8'hFF) return 8'hFF;
    return (c < s[7:0]) ? s[15:8] + 8'd1 : s[15:8];
  endfunction

  always @(posedge clk) begin
    logic last, acc;
    if (!rst_n || !en) begin
      m_cnt <= '0; m_lfsr <= 16'hACE1; m_ramp <= '0; m_act <= '0;
      m_hold <= '0; m_hv <= 1'b0; m_flag <= 1'b0; m_code <= '0;
    end else begin
      last = (m_cnt >= ((cfg_period == 0) ? 16'd0 : cfg_period - 16'd1));
      acc  = smp_valid;
      m_code <= exp_code(m_act, cfg_mode ? m_ramp : m_lfsr[7:0]);
      m_lfsr <= lfsr_step(m_lfsr);
      m_ramp <= m_ramp + 8'd1;
      m_cnt  <= last ? 16'd0 : m_cnt + 16'd1;
      if (last && m_hv) m_act <= m_hold;
      if (acc) begin m_hold <= smp_data; m_hv <= 1'b1; end
      else if (last) m_hv <= 1'b0;
      if (acc) m_flag <= 1'b0;
      else if (last) m_flag <= 1'b1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(ctag, dac_code, m_code);
    chk("R3", period_done, m_flag);
    chk("R2", smp_ready, en && rst_n);
  endtask

  task automatic wr(logic [15:0] d);
    smp_valid = 1'b1;
    smp_data  = d;
    step();
    smp_valid = 1'b0;
    chk("R4", period_done, 1'b0);
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 70000 && !period_done; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk("R1", dac_code, 8'h00);
    chk("R2", smp_ready, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1", period_done, 1'b0);
    en = 1'b1;

    // R9: mid-scale sample
    ctag = "R9";
    cfg_period = 16'd16;
    step();
    wr(16'h8000);
    wait_flag();
    step();
    for (int i = 0; i < 20; i++) begin step(); chk("R9", dac_code, 8'h80); end

    // R6: random dither
    ctag = "R6";
    cfg_period = 16'd8;
    wr(16'h12C0);
    for (int i = 0; i < 200; i++) begin
      if (period_done) wr(16'(($urandom() % 16'hFF00)));
      else step();
    end

    // R7: PWM dither
    ctag = "R7";
    cfg_mode = 1'b1;
    cfg_period = 16'd32;
    wr(16'h3A40);
    for (int i = 0; i < 300; i++) begin
      if (period_done) wr(16'($urandom()));
      else step();
    end

    // R8: saturation at the top base
    ctag = "R8";
    wr(16'hFFF0);
    wait_flag();
    step();
    for (int i = 0; i < 40; i++) begin step(); chk("R8", dac_code, 8'hFF); end

    // R5: held sample waits for the boundary
    ctag = "R5";
    cfg_period = 16'd64;
    wr(16'h4000);
    wait_flag();
    step();
    wr(16'h2000);
    for (int i = 0; i < 20; i++) begin step(); chk("R5", dac_code, 8'h40); end
    wait_flag();
    step();
    chk("R5", dac_code, 8'h20);

    // R1: disable parks the block
    ctag = "R1";
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R1", dac_code, 8'h00);
      chk("R1", period_done, 1'b0);
    end
    en = 1'b1;

    // Mixed random stream
    for (int i = 0; i < 4000; i++) begin
      if (i % 400 == 0) begin
        cfg_mode = ~cfg_mode;
        case ($urandom() % 4)
          0: cfg_period = 16'd0;
          1: cfg_period = 16'd1;
          2: cfg_period = 16'd2;
          default: cfg_period = 16'(3 + $urandom() % 38);
        endcase
      end
      ctag = cfg_mode ? "R7" : "R6";
      if ($urandom() % 150 == 0) en = 1'b0;
      else if (!en && ($urandom() % 4 == 0)) en = 1'b1;
      if (en && ((period_done && ($urandom() % 2 == 0)) || ($urandom() % 25 == 0))) begin
        case ($urandom() % 6)
          0: wr({8'hFF, 8'($urandom())});
          1: wr({8'($urandom()), 8'h00});
          2: wr({8'($urandom()), 8'hFF});
          default: wr(16'($urandom()));
        endcase
      end else begin
        step();
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule